// File: doc/BRIEF.md
# Switch-on-Event Thread Context Controller

This block schedules a small pool of hardware thread contexts for a coarse-grain multithreaded core. Each context is always in one of four states: running, ready, stalled or swapped out. At most one context runs at a time. When the running thread takes a long-latency event such as a cache miss, it is parked in the stalled state, and the controller moves the pipeline to another context that is ready.

A switch loads an active-context register and a process-ID register and then runs a fixed sequence of cycles. The pipeline is held for the whole sequence. The highest-numbered context is kept for the interrupt handler. It leaves the swapped state only on an external interrupt request. Once it is ready, it displaces a running user thread. When the handler gives up the core it returns to the swapped state.

User threads are chosen in round-robin order. If nothing can run, the controller raises an all-blocked flag and keeps the pipeline idle until some context becomes ready.

Top module: `ctx_switch_ctrl`

## Requirements
- R1: After reset, context 0 is running and every other context is swapped out. The outputs read active index 0, PID 0, stall low and all-blocked low.
- R2: A miss on the running thread, outside a switch, moves that thread to stalled. The stall output rises in the cycle after the miss is sampled.
- R3: A bit of ctx_wake_i moves a stalled context, or a swapped user context, to ready. A wake bit for the swapped reserved context is ignored.
- R4: A switch holds stall high for exactly SWITCH_CYCLES (4) cycles. Active index and PID keep their old values until the sequence ends. Both then take the target's value in the same cycle that stall falls.
- R5: The next user context is the first ready one found by searching upward from the current index, wrapping around and skipping the reserved context (index 3).
- R6: A preemption of a running user thread sends it to ready and switches to the next ready context. If no other context is ready, the preemption is ignored.
- R7: If a miss finds no ready context, all_blocked_o and stall_o stay high. The first cycle after some context becomes ready, a switch to it starts.
- R8: irq_req_i moves the swapped reserved context to ready. In the next cycle it displaces a running user thread, which goes back to ready.
- R9: When the reserved context is ready, it is chosen ahead of any ready user context.
- R10: A preemption of the running handler sends it back to swapped. It stays there until the next interrupt request.
- R11: Miss and preemption inputs have no effect while stall is high.
- R12: The PID output always equals the active context index, zero-extended to PID_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_evt_i | input | 1 | Long-latency miss taken by the running thread |
| preempt_i | input | 1 | Request to take the core away from the running thread |
| irq_req_i | input | 1 | External request that wakes the reserved handler context |
| ctx_wake_i | input | NUM_CTX | Per-context wake: miss complete, or user thread loaded |
| active_ctx_o | output | IDX_W | Index of the register set in use |
| pid_o | output | PID_W | Process ID of the active context |
| stall_o | output | 1 | Pipeline hold during a switch or while idle |
| all_blocked_o | output | 1 | No context can run |

## Verification
Some properties are checked by assertions on every cycle. These are: the switch never holds stall longer than its fixed length, the active index changes only as stall falls, a miss outside a switch raises stall next cycle, the all-blocked flag implies stall, and the PID tracks the active index. The other behaviours need the state that earlier events left behind, so only directed scenarios show them. These are the round-robin order with wrap-around and the skipped reserved slot, the ignored preemption, and the interrupt's priority over user threads. They also cover the handler returning to swapped and wake bits aimed at the reserved slot.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

    typedef enum logic [1:0] {
        CTX_RUN   = 2'd0,
        CTX_READY = 2'd1,
        CTX_STALL = 2'd2,
        CTX_SWAP  = 2'd3
    } ctx_state_t;

    typedef enum logic [1:0] {
        PH_RUN    = 2'd0,
        PH_SWITCH = 2'd1,
        PH_IDLE   = 2'd2
    } phase_t;

    // Command that takes the running context out of the running state
    typedef struct packed {
        logic       valid;
        ctx_state_t dest;
    } leave_cmd_t;

    function automatic int ring_step(input int base, input int k, input int n);
        return (base + k) % n;
    endfunction

endpackage

// File: rtl/ctx_state_table.sv
module ctx_state_table
    import ctxsw_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int IRQ_CTX = 3,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CTX-1:0] wake,
    input  logic               irq_req,
    input  leave_cmd_t         leave,
    input  logic [IDX_W-1:0]   cur_ctx,
    input  logic               enter_valid,
    input  logic [IDX_W-1:0]   enter_ctx,
    output logic [NUM_CTX-1:0] ready_vec
);

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        localparam bit IS_IRQ = (g == IRQ_CTX);
        ctx_state_t st;

        always_ff @(posedge clk) begin
            if (rst) begin
                st <= (g == 0) ? CTX_RUN : CTX_SWAP;
            end else if (enter_valid && enter_ctx == IDX_W'(g)) begin
                st <= CTX_RUN;
            end else if (leave.valid && cur_ctx == IDX_W'(g)) begin
                st <= leave.dest;
            end else if (st == CTX_STALL && wake[g]) begin
                st <= CTX_READY;
            end else if (st == CTX_SWAP && !IS_IRQ && wake[g]) begin
                st <= CTX_READY;
            end else if (st == CTX_SWAP && IS_IRQ && irq_req) begin
                st <= CTX_READY;
            end
        end

        assign ready_vec[g] = (st == CTX_READY);
    end

endmodule

// File: rtl/ctx_picker.sv
module ctx_picker
    import ctxsw_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int IRQ_CTX = 3,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_CTX-1:0] ready_vec,
    input  logic [IDX_W-1:0]   cur_ctx,
    output logic               found,
    output logic [IDX_W-1:0]   pick
);

    always_comb begin
        found = 1'b0;
        pick  = '0;
        if (ready_vec[IRQ_CTX]) begin
            found = 1'b1;
            pick  = IDX_W'(IRQ_CTX);
        end else begin
            for (int k = 1; k <= NUM_CTX; k++) begin
                automatic int idx = ring_step(int'(cur_ctx), k, NUM_CTX);
                if (!found && idx != IRQ_CTX && ready_vec[idx]) begin
                    found = 1'b1;
                    pick  = IDX_W'(idx);
                end
            end
        end
    end

endmodule

// File: rtl/ctx_switch_seq.sv
module ctx_switch_seq
    import ctxsw_pkg::*;
#(
    parameter int NUM_CTX       = 4,
    parameter int IRQ_CTX       = 3,
    parameter int IDX_W         = 2,
    parameter int PID_W         = 8,
    parameter int SWITCH_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             miss,
    input  logic             preempt,
    input  logic             irq_ready,
    input  logic             found,
    input  logic [IDX_W-1:0] pick,
    output logic [IDX_W-1:0] active,
    output logic [PID_W-1:0] pid,
    output logic             stall,
    output logic             all_blocked,
    output leave_cmd_t       leave,
    output logic             enter_valid,
    output logic [IDX_W-1:0] enter_ctx
);

    localparam int CNT_W = (SWITCH_CYCLES > 1) ? $clog2(SWITCH_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SWITCH_CYCLES - 1);
    localparam logic [IDX_W-1:0] IRQ_IDX = IDX_W'(IRQ_CTX);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] target;
    logic             start_sw;
    logic             go_idle;

    always_comb begin
        leave    = '{valid: 1'b0, dest: CTX_READY};
        start_sw = 1'b0;
        go_idle  = 1'b0;
        unique case (phase)
            PH_RUN: begin
                if (miss) begin
                    leave = '{valid: 1'b1, dest: CTX_STALL};
                    start_sw = found;
                    go_idle  = !found;
                end else if (preempt && active == IRQ_IDX) begin
                    leave = '{valid: 1'b1, dest: CTX_SWAP};
                    start_sw = found;
                    go_idle  = !found;
                end else if (preempt && found) begin
                    leave = '{valid: 1'b1, dest: CTX_READY};
                    start_sw = 1'b1;
                end else if (irq_ready && active != IRQ_IDX) begin
                    leave = '{valid: 1'b1, dest: CTX_READY};
                    start_sw = 1'b1;
                end
            end
            PH_IDLE:   start_sw = found;
            PH_SWITCH: ;
            default:   ;
        endcase
    end

    assign enter_valid = (phase == PH_SWITCH) && (cnt == '0);
    assign enter_ctx   = target;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_RUN;
            cnt    <= '0;
            target <= '0;
            active <= '0;
            pid    <= '0;
        end else if (start_sw) begin
            phase  <= PH_SWITCH;
            cnt    <= LAST;
            target <= pick;
        end else if (go_idle) begin
            phase <= PH_IDLE;
        end else if (enter_valid) begin
            phase  <= PH_RUN;
            active <= target;
            pid    <= PID_W'(target);
        end else if (phase == PH_SWITCH) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign stall       = (phase != PH_RUN);
    assign all_blocked = (phase == PH_IDLE);

endmodule

// File: rtl/ctx_switch_ctrl.sv
module ctx_switch_ctrl
    import ctxsw_pkg::*;
#(
    parameter int NUM_CTX       = 4,
    parameter int IRQ_CTX       = NUM_CTX - 1,
    parameter int PID_W         = 8,
    parameter int SWITCH_CYCLES = 4,
    localparam int IDX_W        = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               miss_evt_i,
    input  logic               preempt_i,
    input  logic               irq_req_i,
    input  logic [NUM_CTX-1:0] ctx_wake_i,
    output logic [IDX_W-1:0]   active_ctx_o,
    output logic [PID_W-1:0]   pid_o,
    output logic               stall_o,
    output logic               all_blocked_o
);

    logic [NUM_CTX-1:0] ready_vec;
    logic               found;
    logic [IDX_W-1:0]   pick;
    leave_cmd_t         leave;
    logic               enter_valid;
    logic [IDX_W-1:0]   enter_ctx;

    ctx_state_table #(
        .NUM_CTX(NUM_CTX), .IRQ_CTX(IRQ_CTX), .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst(rst), .wake(ctx_wake_i), .irq_req(irq_req_i),
        .leave(leave), .cur_ctx(active_ctx_o),
        .enter_valid(enter_valid), .enter_ctx(enter_ctx),
        .ready_vec(ready_vec)
    );

    ctx_picker #(
        .NUM_CTX(NUM_CTX), .IRQ_CTX(IRQ_CTX), .IDX_W(IDX_W)
    ) u_picker (
        .ready_vec(ready_vec), .cur_ctx(active_ctx_o),
        .found(found), .pick(pick)
    );

    ctx_switch_seq #(
        .NUM_CTX(NUM_CTX), .IRQ_CTX(IRQ_CTX), .IDX_W(IDX_W),
        .PID_W(PID_W), .SWITCH_CYCLES(SWITCH_CYCLES)
    ) u_seq (
        .clk(clk), .rst(rst), .miss(miss_evt_i), .preempt(preempt_i),
        .irq_ready(ready_vec[IRQ_CTX]), .found(found), .pick(pick),
        .active(active_ctx_o), .pid(pid_o), .stall(stall_o),
        .all_blocked(all_blocked_o), .leave(leave),
        .enter_valid(enter_valid), .enter_ctx(enter_ctx)
    );

endmodule

// File: rtl/ctx_switch_checker.sv
module ctx_switch_checker #(
    parameter int IDX_W         = 2,
    parameter int PID_W         = 8,
    parameter int SWITCH_CYCLES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             miss_evt_i,
    input logic             stall_o,
    input logic             all_blocked_o,
    input logic [IDX_W-1:0] active_ctx_o,
    input logic [PID_W-1:0] pid_o
);

    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !stall_o || all_blocked_o) begin
            run_len <= '0;
        end else if (run_len != 16'hFFFF) begin
            run_len <= run_len + 1'b1;
        end
    end

    assert_switch_len_R4: assert property (@(posedge clk) disable iff (rst)
        (stall_o && !all_blocked_o) |-> (32'(run_len) < SWITCH_CYCLES));

    assert_active_on_end_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_ctx_o) |-> $fell(stall_o));

    assert_miss_stalls_R2: assert property (@(posedge clk) disable iff (rst)
        (miss_evt_i && !stall_o) |=> stall_o);

    assert_blocked_holds_R7: assert property (@(posedge clk) disable iff (rst)
        all_blocked_o |-> stall_o);

    assert_pid_match_R12: assert property (@(posedge clk) disable iff (rst)
        pid_o == PID_W'(active_ctx_o));

endmodule

bind ctx_switch_ctrl ctx_switch_checker #(
    .IDX_W(IDX_W), .PID_W(PID_W), .SWITCH_CYCLES(SWITCH_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .miss_evt_i(miss_evt_i), .stall_o(stall_o),
    .all_blocked_o(all_blocked_o), .active_ctx_o(active_ctx_o), .pid_o(pid_o)
);

// File: tb/test_ctx_switch_ctrl.sv
`timescale 1ns/1ps
module test_ctx_switch_ctrl;

    localparam int N  = 4;
    localparam int SW = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         miss = 1'b0;
    logic         preempt = 1'b0;
    logic         irq = 1'b0;
    logic [N-1:0] wake = '0;
    logic [1:0]   active;
    logic [7:0]   pid;
    logic         stall;
    logic         blocked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ctx_switch_ctrl #(.NUM_CTX(N), .PID_W(8), .SWITCH_CYCLES(SW)) i_ctx_switch_ctrl (
        .clk(clk), .rst(rst), .miss_evt_i(miss), .preempt_i(preempt),
        .irq_req_i(irq), .ctx_wake_i(wake), .active_ctx_o(active),
        .pid_o(pid), .stall_o(stall), .all_blocked_o(blocked)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fire(input bit m, input bit p, input bit q, input logic [N-1:0] w);
        miss = m; preempt = p; irq = q; wake = w;
        @(negedge clk);
        miss = 1'b0; preempt = 1'b0; irq = 1'b0; wake = '0;
    endtask

    // Called in the first cycle after the switch started
    task automatic expect_switch(input int old_ctx, input int tgt, input string req);
        for (int k = 0; k < SW; k++) begin
            chk(req, "stall during switch", int'(stall), 1);
            chk("R4", "active held during switch", int'(active), old_ctx);
            @(negedge clk);
        end
        chk(req, "stall after switch", int'(stall), 0);
        chk(req, "active after switch", int'(active), tgt);
        chk("R12", "pid after switch", int'(pid), tgt);
        chk(req, "blocked after switch", int'(blocked), 0);
    endtask

    task automatic expect_steady(input int ctx, input int cycles, input string req);
        for (int k = 0; k < cycles; k++) begin
            chk(req, "no stall", int'(stall), 0);
            chk(req, "active unchanged", int'(active), ctx);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "active", int'(active), 0);
        chk("R1", "pid", int'(pid), 0);
        chk("R1", "stall", int'(stall), 0);
        chk("R1", "blocked", int'(blocked), 0);

        // R3: wake swapped users 1 and 2
        fire(0, 0, 0, 4'b0110);
        expect_steady(0, 2, "R3");
        // R2/R5: miss on 0 -> 1
        fire(1, 0, 0, '0);
        expect_switch(0, 1, "R2");
        // R3 miss done on 0; R5 miss on 1 -> 2
        fire(0, 0, 0, 4'b0001);
        fire(1, 0, 0, '0);
        expect_switch(1, 2, "R5");
        // R5/R6: preempt on 2 wraps past reserved 3 to 0
        fire(0, 1, 0, '0);
        expect_switch(2, 0, "R5");
        // R6: preempted 2 is ready again
        fire(1, 0, 0, '0);
        expect_switch(0, 2, "R6");
        // R6: nothing else ready -> preempt ignored
        fire(0, 1, 0, '0);
        expect_steady(2, 3, "R6");
        // R7: miss with nothing ready -> idle
        fire(1, 0, 0, '0);
        for (int k = 0; k < 3; k++) begin
            chk("R7", "blocked", int'(blocked), 1);
            chk("R7", "stall while idle", int'(stall), 1);
            @(negedge clk);
        end
        fire(0, 0, 0, 4'b0010);
        chk("R7", "blocked until picked", int'(blocked), 1);
        @(negedge clk);
        expect_switch(2, 1, "R7");
        // R8: interrupt wakes handler, displaces user 1
        fire(0, 0, 1, '0);
        chk("R8", "not yet switching", int'(stall), 0);
        @(negedge clk);
        expect_switch(1, 3, "R8");
        // R10: handler yields -> swapped; user 1 runs and is not displaced
        fire(0, 1, 0, '0);
        expect_switch(3, 1, "R10");
        expect_steady(1, 3, "R10");
        // R11: events during the switch are ignored
        fire(0, 0, 0, 4'b0101);
        fire(1, 0, 0, '0);
        chk("R11", "switch started", int'(stall), 1);
        fire(1, 1, 0, '0);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R11", "active after switch", int'(active), 2);
        expect_steady(2, 4, "R11");
        // R9: handler wins over ready user
        fire(1, 0, 0, '0);
        expect_switch(2, 0, "R5");
        fire(1, 0, 0, '0);
        chk("R7", "blocked again", int'(blocked), 1);
        fire(0, 0, 1, 4'b0010);
        @(negedge clk);
        expect_switch(0, 3, "R9");
        // R3: wake bit for the swapped reserved context ignored
        fire(0, 1, 0, '0);
        expect_switch(3, 1, "R10");
        fire(0, 0, 0, 4'b1000);
        expect_steady(1, 4, "R3");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule